// File: doc/BRIEF.md
# SPI Control-Register Port with Commit

This block is the peripheral end of a four-wire serial link into a high-speed converter's control space. A host drives a frame while holding chip select low. The frame opens with a 16-bit instruction, sent most significant bit first. Bit 15 of the instruction is the read flag, and bits 14:0 hold the register address. A write frame is followed by one data byte. A read frame is followed by the block shifting the selected byte back to the host.

Written values are held in shadow registers and have no effect yet. They move into the active registers, all in the same cycle, when the host writes to the transfer register with its commit bit set. The active values drive the converter datapath on dedicated outputs.

The serial inputs are brought into the system clock domain through synchronizers. For this reason the serial clock must be several times slower than `clk`. A half period of at least four `clk` cycles is assumed.

Top module: `spi_reg_port`

## Requirements
- R1: Serial mode 0. Data is sampled on rising `spiSclk` edges with the most significant bit first. Instruction bit 15 set to 1 marks a read, and bits 14:0 are the address.
- R2: A write frame of 24 bits updates only the shadow copy of the addressed register. The outputs and read-back keep their old values until a commit.
- R3: A write to address 0x00FF with data bit 0 set to 1 copies all five shadows into the active registers at once. The same write with bit 0 clear changes nothing.
- R4: Reading address 0x00FF always returns 0x00, because the commit bit clears itself.
- R5: Reading a writable register returns its active value, not its pending shadow value. The writable registers are 0x000D (test mode), 0x0014 (output mode), 0x0016 (output phase), 0x0017 (output delay) and 0x0018 (reference select).
- R6: Address 0x0001 reads back the `CHIP_ID` parameter and address 0x0002 reads back the `SPEED_GRADE` parameter. Writes to these two addresses are ignored.
- R7: Any other address reads 0x00 and ignores writes. This includes any address with a nonzero bit in 14:8.
- R8: If chip select rises before the 24th rising edge, the frame is abandoned and no register changes. Clock edges after the 24th are ignored.
- R9: `spiMiso` changes only after falling `spiSclk` edges. It carries the read byte during bits 16 to 23 of a read frame and is 0 otherwise, including during write frames and while chip select is high.
- R10: After reset, all shadow and active registers are 0x00 and `spiMiso` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| spiSclk | input | 1 | Serial clock from the host |
| spiCsN | input | 1 | Active-low chip select framing each transfer |
| spiMosi | input | 1 | Serial data from the host |
| spiMiso | output | 1 | Serial read data to the host |
| testModeQ | output | 8 | Active test-mode register (0x000D) |
| outModeQ | output | 8 | Active output-mode register (0x0014) |
| outPhaseQ | output | 8 | Active output-phase register (0x0016) |
| outDelayQ | output | 8 | Active output-delay register (0x0017) |
| refSelQ | output | 8 | Active reference-select register (0x0018) |

## Verification
The hardest state to reach is a divergence between shadow and active values. It is only visible when a write has landed but no commit has followed. The stimulus writes all five registers and then issues a commit write with bit 0 clear. Both the outputs and the serial read-back must still show the old active values at that point.

Frame aborts are exercised at the point where they would do the most damage: a write stopped one bit short of completion. An overlong frame checks the opposite case, showing that trailing clock edges cannot alter a value that has already been stored.

// File: rtl/spireg_pkg.sv
package spireg_pkg;
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 15;
  localparam int INSTR_BITS = ADDR_W + 1;
  localparam int FRAME_BITS = INSTR_BITS + DATA_W;
  localparam int NUM_REGS   = 5;
  localparam int COMMIT_BIT = 0;

  localparam logic [ADDR_W-1:0] XFER_ADDR  = 15'h00FF;
  localparam logic [ADDR_W-1:0] ID_ADDR    = 15'h0001;
  localparam logic [ADDR_W-1:0] GRADE_ADDR = 15'h0002;

  localparam int IDX_TEST  = 0;
  localparam int IDX_MODE  = 1;
  localparam int IDX_PHASE = 2;
  localparam int IDX_DELAY = 3;
  localparam int IDX_REF   = 4;

  localparam logic [ADDR_W-1:0] REG_ADDR [NUM_REGS] =
    '{15'h000D, 15'h0014, 15'h0016, 15'h0017, 15'h0018};

  typedef struct packed {
    logic              wrEn;
    logic [ADDR_W-1:0] wrAddr;
    logic [DATA_W-1:0] wrData;
    logic [ADDR_W-1:0] rdAddr;
  } ctlStrobe_t;
endpackage

// File: rtl/spi_frame_ctl.sv
module spi_frame_ctl
  import spireg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              spiSclk,
  input  logic              spiCsN,
  input  logic              spiMosi,
  input  logic [DATA_W-1:0] rdData,
  output ctlStrobe_t        strobe,
  output logic              spiMiso
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);

  logic [SYNC_STAGES:0]   sclkPipe;
  logic [SYNC_STAGES-1:0] csPipe;
  logic [SYNC_STAGES-1:0] mosiPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPipe <= '0;
      csPipe   <= '1;
      mosiPipe <= '0;
    end else begin
      sclkPipe <= {sclkPipe[SYNC_STAGES-1:0], spiSclk};
      csPipe   <= {csPipe[SYNC_STAGES-2:0], spiCsN};
      mosiPipe <= {mosiPipe[SYNC_STAGES-2:0], spiMosi};
    end
  end

  logic riseEvt, fallEvt, csActive, mosiNow;
  assign riseEvt  =  sclkPipe[SYNC_STAGES-1] & ~sclkPipe[SYNC_STAGES];
  assign fallEvt  = ~sclkPipe[SYNC_STAGES-1] &  sclkPipe[SYNC_STAGES];
  assign csActive = ~csPipe[SYNC_STAGES-1];
  assign mosiNow  =  mosiPipe[SYNC_STAGES-1];

  logic [CNT_W-1:0]      bitCnt;
  logic [ADDR_W-1:0]     shiftIn;
  logic [INSTR_BITS-1:0] instrQ;
  logic [DATA_W-2:0]     txReg;
  logic                  misoQ;
  logic                  wrEnQ;
  logic [ADDR_W-1:0]     wrAddrQ;
  logic [DATA_W-1:0]     wrDataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      shiftIn <= '0;
      instrQ  <= '0;
      txReg   <= '0;
      misoQ   <= 1'b0;
      wrEnQ   <= 1'b0;
      wrAddrQ <= '0;
      wrDataQ <= '0;
    end else begin
      wrEnQ <= 1'b0;
      if (!csActive) begin
        bitCnt <= '0;
        txReg  <= '0;
        misoQ  <= 1'b0;
      end else begin
        if (riseEvt && bitCnt != CNT_W'(FRAME_BITS)) begin
          shiftIn <= {shiftIn[ADDR_W-2:0], mosiNow};
          bitCnt  <= bitCnt + 1'b1;
          if (bitCnt == CNT_W'(INSTR_BITS - 1))
            instrQ <= {shiftIn, mosiNow};
          if (bitCnt == CNT_W'(FRAME_BITS - 1) && !instrQ[INSTR_BITS-1]) begin
            wrEnQ   <= 1'b1;
            wrAddrQ <= instrQ[ADDR_W-1:0];
            wrDataQ <= {shiftIn[DATA_W-2:0], mosiNow};
          end
        end
        if (fallEvt) begin
          if (bitCnt == CNT_W'(INSTR_BITS) && instrQ[INSTR_BITS-1]) begin
            misoQ <= rdData[DATA_W-1];
            txReg <= rdData[DATA_W-2:0];
          end else if (bitCnt > CNT_W'(INSTR_BITS)) begin
            misoQ <= txReg[DATA_W-2];
            txReg <= {txReg[DATA_W-3:0], 1'b0};
          end
        end
      end
    end
  end

  always_comb begin
    strobe.wrEn   = wrEnQ;
    strobe.wrAddr = wrAddrQ;
    strobe.wrData = wrDataQ;
    strobe.rdAddr = instrQ[ADDR_W-1:0];
  end

  assign spiMiso = misoQ;
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spireg_pkg::*;
#(
  parameter logic [DATA_W-1:0] CHIP_ID     = 8'hA7,
  parameter logic [DATA_W-1:0] SPEED_GRADE = 8'h03
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] activeQ [NUM_REGS]
);
  logic commitNow;
  assign commitNow = strobe.wrEn && strobe.wrAddr == XFER_ADDR
                     && strobe.wrData[COMMIT_BIT];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [DATA_W-1:0] shadowQ;
    logic              hit;
    assign hit = strobe.wrEn && strobe.wrAddr == REG_ADDR[i];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        shadowQ    <= '0;
        activeQ[i] <= '0;
      end else begin
        if (hit)       shadowQ    <= strobe.wrData;
        if (commitNow) activeQ[i] <= shadowQ;
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (strobe.rdAddr == ID_ADDR)    rdData = CHIP_ID;
    if (strobe.rdAddr == GRADE_ADDR) rdData = SPEED_GRADE;
    for (int i = 0; i < NUM_REGS; i++)
      if (strobe.rdAddr == REG_ADDR[i]) rdData = activeQ[i];
  end
endmodule

// File: rtl/spi_reg_port.sv
module spi_reg_port
  import spireg_pkg::*;
#(
  parameter logic [DATA_W-1:0] CHIP_ID     = 8'hA7,
  parameter logic [DATA_W-1:0] SPEED_GRADE = 8'h03,
  parameter int                SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        spiSclk,
  input  logic        spiCsN,
  input  logic        spiMosi,
  output logic        spiMiso,
  output logic [7:0]  testModeQ,
  output logic [7:0]  outModeQ,
  output logic [7:0]  outPhaseQ,
  output logic [7:0]  outDelayQ,
  output logic [7:0]  refSelQ
);
  ctlStrobe_t        strobe;
  logic [DATA_W-1:0] rdData;
  logic [DATA_W-1:0] activeQ [NUM_REGS];

  spi_frame_ctl #(.SYNC_STAGES(SYNC_STAGES)) ctlInst (
    .clk(clk), .rstN(rstN), .spiSclk(spiSclk), .spiCsN(spiCsN),
    .spiMosi(spiMosi), .rdData(rdData), .strobe(strobe), .spiMiso(spiMiso)
  );

  spi_reg_bank #(.CHIP_ID(CHIP_ID), .SPEED_GRADE(SPEED_GRADE)) bankInst (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdData(rdData), .activeQ(activeQ)
  );

  assign testModeQ = activeQ[IDX_TEST];
  assign outModeQ  = activeQ[IDX_MODE];
  assign outPhaseQ = activeQ[IDX_PHASE];
  assign outDelayQ = activeQ[IDX_DELAY];
  assign refSelQ   = activeQ[IDX_REF];
endmodule

// File: rtl/spi_reg_port_chk.sv
module spi_reg_port_chk
  import spireg_pkg::*;
#(
  parameter logic [DATA_W-1:0] CHIP_ID     = 8'hA7,
  parameter logic [DATA_W-1:0] SPEED_GRADE = 8'h03
) (
  input logic              clk,
  input logic              rstN,
  input logic              spiCsN,
  input logic              spiMiso,
  input logic [7:0]        testModeQ,
  input logic [7:0]        outModeQ,
  input logic [7:0]        outPhaseQ,
  input logic [7:0]        outDelayQ,
  input logic [7:0]        refSelQ,
  input ctlStrobe_t        strobe,
  input logic [DATA_W-1:0] rdData
);
  logic [39:0] outsAll;
  assign outsAll = {testModeQ, outModeQ, outPhaseQ, outDelayQ, refSelQ};

  // R3
  active_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.wrEn && strobe.wrAddr == XFER_ADDR && strobe.wrData[COMMIT_BIT])
    |=> $stable(outsAll));

  // R4
  xfer_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdAddr == XFER_ADDR |-> rdData == '0);

  // R6
  chip_id_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdAddr == ID_ADDR |-> rdData == CHIP_ID);

  // R6
  grade_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdAddr == GRADE_ADDR |-> rdData == SPEED_GRADE);

  // R7
  high_addr_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdAddr[ADDR_W-1:8] != '0 |-> rdData == '0);

  // R9
  idle_miso_chk: assert property (@(posedge clk) disable iff (!rstN)
    (spiCsN && $past(spiCsN) && $past(spiCsN, 2) && $past(spiCsN, 3))
    |-> !spiMiso);

  // R10
  reset_state_chk: assert property (@(posedge clk)
    (rstN && !$past(rstN)) |-> (outsAll == '0 && !spiMiso));
endmodule

bind spi_reg_port spi_reg_port_chk #(.CHIP_ID(CHIP_ID), .SPEED_GRADE(SPEED_GRADE)) chkInst (
  .clk(clk), .rstN(rstN), .spiCsN(spiCsN), .spiMiso(spiMiso),
  .testModeQ(testModeQ), .outModeQ(outModeQ), .outPhaseQ(outPhaseQ),
  .outDelayQ(outDelayQ), .refSelQ(refSelQ), .strobe(strobe), .rdData(rdData)
);

// File: tb/spi_reg_port_test.sv
module spi_reg_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;
  localparam logic [7:0] ID_VAL = 8'hA7;
  localparam logic [7:0] GRADE_VAL = 8'h03;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic spiSclk = 1'b0;
  logic spiCsN = 1'b1;
  logic spiMosi = 1'b0;
  logic spiMiso;
  logic [7:0] testModeQ, outModeQ, outPhaseQ, outDelayQ, refSelQ;

  int compared = 0;
  int mismatched = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_reg_port #(.CHIP_ID(ID_VAL), .SPEED_GRADE(GRADE_VAL)) uut (
    .clk(clk), .rstN(rstN), .spiSclk(spiSclk), .spiCsN(spiCsN),
    .spiMosi(spiMosi), .spiMiso(spiMiso), .testModeQ(testModeQ),
    .outModeQ(outModeQ), .outPhaseQ(outPhaseQ), .outDelayQ(outDelayQ),
    .refSelQ(refSelQ)
  );

  logic [7:0] expQ[$];
  string tagQ[$];

  task automatic checkVal(input string tag, input logic [39:0] got, input logic [39:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // monitor: observes the serial lines, compares read bytes against the queue
  logic [31:0] monMosi = '0;
  logic [23:0] monMiso = '0;
  int monCnt = 0;

  always @(posedge spiSclk) begin
    if (!spiCsN) begin
      monMosi = {monMosi[30:0], spiMosi};
      monMiso = {monMiso[22:0], spiMiso};
      monCnt++;
    end
  end

  always @(posedge spiCsN) begin
    if (monCnt == 24 && monMosi[23]) begin
      if (expQ.size() == 0) begin
        compared++; mismatched++;
        $display("FAIL R1: unexpected read result %h expected none", monMiso[7:0]);
      end else begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        checkVal(t, {32'h0, monMiso[7:0]}, {32'h0, e});
      end
    end else if (monCnt == 24) begin
      // R9: no read data driven during a write frame
      checkVal("R9 miso quiet in write frame", {16'h0, monMiso}, 40'h0);
    end
    monCnt = 0;
  end

  task automatic sendFrame(input logic [31:0] bits, input int nBits);
    @(negedge clk); spiCsN = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = nBits - 1; i >= 0; i--) begin
      spiMosi = bits[i];
      repeat (HALF) @(negedge clk);
      spiSclk = 1'b1;
      repeat (HALF) @(negedge clk);
      spiSclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    spiCsN = 1'b1; spiMosi = 1'b0;
    repeat (3*HALF) @(negedge clk);
  endtask

  task automatic writeReg(input logic [14:0] addr, input logic [7:0] data);
    sendFrame({8'h00, 1'b0, addr, data}, 24);
  endtask

  task automatic readReg(input logic [14:0] addr, input logic [7:0] exp, input string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    sendFrame({8'h00, 1'b1, addr, 8'h00}, 24);
  endtask

  function automatic logic [39:0] outs();
    return {testModeQ, outModeQ, outPhaseQ, outDelayQ, refSelQ};
  endfunction

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    // R10 reset state
    checkVal("R10 outputs after reset", outs(), 40'h0);
    checkVal("R10 miso after reset", {39'h0, spiMiso}, 40'h0);

    // R6 identity, R1 read framing
    readReg(15'h0001, ID_VAL, "R6 chip id read");
    readReg(15'h0002, GRADE_VAL, "R6 grade read");

    // R2 shadow writes, not yet active
    writeReg(15'h000D, 8'h05);
    writeReg(15'h0014, 8'h09);
    writeReg(15'h0016, 8'hA0);
    writeReg(15'h0017, 8'h13);
    writeReg(15'h0018, 8'h81);
    checkVal("R2 outputs unchanged before commit", outs(), 40'h0);
    readReg(15'h0014, 8'h00, "R5 read returns active not shadow");

    // R3 commit bit clear: no effect
    writeReg(15'h00FF, 8'h00);
    checkVal("R3 commit with bit0 clear", outs(), 40'h0);

    // R3 commit
    writeReg(15'h00FF, 8'h01);
    checkVal("R3 commit applies all", outs(), {8'h05, 8'h09, 8'hA0, 8'h13, 8'h81});
    readReg(15'h00FF, 8'h00, "R4 transfer reads zero");
    readReg(15'h0016, 8'hA0, "R5 read active phase");
    readReg(15'h0018, 8'h81, "R5 R1 read active ref msb-first");

    // R6 writes to identity ignored
    writeReg(15'h0001, 8'h33);
    writeReg(15'h0002, 8'h44);
    writeReg(15'h00FF, 8'h01);
    readReg(15'h0001, ID_VAL, "R6 chip id after write");
    readReg(15'h0002, GRADE_VAL, "R6 grade after write");

    // R7 unmapped addresses
    writeReg(15'h0114, 8'h77);
    writeReg(15'h00FF, 8'h01);
    checkVal("R7 high address write ignored", outs(), {8'h05, 8'h09, 8'hA0, 8'h13, 8'h81});
    readReg(15'h0114, 8'h00, "R7 high address reads zero");
    readReg(15'h0033, 8'h00, "R7 unmapped reads zero");

    // R8 aborted frames
    sendFrame({8'h00, 16'h0014, 8'h55} >> 1, 23);
    sendFrame({16'h0000, 16'h000D}, 16);
    writeReg(15'h00FF, 8'h01);
    checkVal("R8 aborted write has no effect", outs(), {8'h05, 8'h09, 8'hA0, 8'h13, 8'h81});

    // R8 trailing clocks ignored
    sendFrame({16'h0014, 8'h3C, 4'hF, 4'h0} >> 4, 28);
    writeReg(15'h00FF, 8'h01);
    checkVal("R8 overlong frame keeps first data byte", outs(), {8'h05, 8'h3C, 8'hA0, 8'h13, 8'h81});
    readReg(15'h0014, 8'h3C, "R8 R5 read after overlong frame");

    // R9 idle miso
    checkVal("R9 miso idle", {39'h0, spiMiso}, 40'h0);

    repeat (10) @(negedge clk);
    checkVal("R1 all reads returned", 40'(expQ.size()), 40'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule